// File: doc/BRIEF.md
# Fuzzy Speed Controller

This block turns a signed speed error into a signed modulation-reference amplitude by fuzzy inference. Each accepted error sample is paired with its change since the previously accepted sample. Both values are graded against seven evenly spaced triangular sets. A fixed 7×7 rule matrix maps each pair of sets to an output set. The firing strengths are combined, and a weighted average of the output set centres gives the result. That result is clamped to the signed output width.

Samples arrive on a valid/ready input stream and results leave on a valid/ready output stream. The block works on one sample at a time. `in_ready` is high only while the block is idle. It drops on the edge that accepts a sample and stays low until the result has been taken. Anything offered on the input while `in_ready` is low is not consumed. A finished result waits on the output with `out_valid` high, and its value holds steady for as long as `out_ready` stays low. The average is formed by a bit-serial divider, so each result appears a fixed number of cycles after its sample is accepted.

Top module: `fz_speed_ctrl`

## Requirements
- R1: On reset, `in_ready` is 1, `out_valid` is 0, and the stored previous error is zero, so the first sample's change of error equals the sample itself.
- R2: A sample is taken on an edge where `in_valid` and `in_ready` are both 1. From that edge until the result is taken, `in_ready` is 0 and any offered sample is ignored: it neither changes the pending result nor becomes the stored previous error.
- R3: `out_valid` rises exactly LAT = MU_W + clog2(21·OUT_STEP+1) + 1 edges after the accepting edge, where MU_W = SH + 1. With the default parameters LAT is 25.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_ref` stays unchanged. After the edge where both are 1, `out_valid` is 0 and `in_ready` is 1.
- R5: The change of error is the accepted error minus the previously accepted error, computed one bit wider than the input so that it cannot wrap.
- R6: For an input x, set k (k = 0..6) has its centre at (k−3)·2^SH. Its membership falls linearly from 2^SH at its own centre to 0 at the neighbouring centres, so at most two adjacent sets are non-zero. For x ≤ −3·2^SH, set 0 has full membership; for x ≥ 3·2^SH, set 6 has full membership.
- R7: Set codes are NB=0, NM=1, NS=2, ZR=3, PS=4, PM=5, PB=6. For error code i and change code j, the output code is digit j of row i:
  - row0 0001123
  - row1 0011234
  - row2 0112345
  - row3 1123455
  - row4 1234556
  - row5 2345566
  - row6 3455666
- R8: A rule fires with the smaller of its two input memberships. The strength of each output set is the largest strength among the rules that map to it.
- R9: The result is Σ s_k·(k−3)·OUT_STEP divided by Σ s_k, where s_k is the strength of output set k, truncated toward zero.
- R10: The result is clamped to the signed OUT_W range, which is [−2048, 2047] by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Error sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_err | input | IN_W | Signed speed error |
| out_valid | output | 1 | Result waiting to be taken |
| out_ready | input | 1 | Consumer takes the result |
| out_ref | output | OUT_W | Signed modulation reference amplitude |

## Verification
The bench builds the block with its defaults: IN_W 16, SH 8, OUT_STEP 1000 and OUT_W 12. A set spacing of 256 lets chosen errors land exactly on set centres or at known fractions between them, so every rule cell, min/max combination and truncated average can be worked out by hand. An output centre spacing of 1000 puts the outer centres at ±3000, beyond the 12-bit range, so both clamp limits can be reached with saturated inputs. The divider then spans 24 steps, which gives a latency of 25 cycles that the bench measures on every sample.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int NSET = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN, ST_HOLD} fz_state_e;

  // output set code per (error set, change set); codes 0..6 run from most negative to most positive
  localparam logic [2:0] RULE_TBL [NSET][NSET] = '{
    '{3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd3},
    '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd3, 3'd4},
    '{3'd0, 3'd1, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5},
    '{3'd1, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5},
    '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6},
    '{3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6},
    '{3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6, 3'd6}
  };
endpackage

// File: rtl/fz_fuzzify.sv
module fz_fuzzify #(
  parameter int X_W  = 16,
  parameter int SH   = 8,
  parameter int MU_W = SH + 1
) (
  input  logic signed [X_W-1:0]               x_i,
  output logic [fz_pkg::NSET-1:0][MU_W-1:0]   mu_o
);
  localparam int PW = X_W + 2;
  localparam logic signed [X_W-1:0] LIM  = X_W'(3 * (2 ** SH));
  localparam logic [MU_W-1:0]       FULL = MU_W'(2 ** SH);

  logic [PW-1:0] pos;
  logic [2:0]    seg;
  logic [SH-1:0] frac;

  always_comb begin
    // shift so the most negative centre sits at zero
    pos  = {{2{x_i[X_W-1]}}, x_i} + PW'(3 * (2 ** SH));
    seg  = 3'(pos >> SH);
    frac = pos[SH-1:0];
    mu_o = '0;
    if (x_i <= -LIM) begin
      mu_o[0] = FULL;
    end else if (x_i >= LIM) begin
      mu_o[fz_pkg::NSET-1] = FULL;
    end else begin
      for (int k = 0; k < fz_pkg::NSET; k++) begin
        if (3'(k) == seg)             mu_o[k] = FULL - MU_W'(frac);
        else if (3'(k) == seg + 3'd1) mu_o[k] = MU_W'(frac);
      end
    end
  end
endmodule

// File: rtl/fz_rulebank.sv
module fz_rulebank #(
  parameter int MU_W     = 9,
  parameter int OUT_STEP = 1000,
  parameter int NUM_W    = 25,
  parameter int DEN_W    = 12
) (
  input  logic [fz_pkg::NSET-1:0][MU_W-1:0] mu_e_i,
  input  logic [fz_pkg::NSET-1:0][MU_W-1:0] mu_d_i,
  output logic signed [NUM_W-1:0]           num_o,
  output logic [DEN_W-1:0]                  den_o
);
  import fz_pkg::*;

  logic [NSET-1:0][MU_W-1:0] agg;

  always_comb begin
    logic [MU_W-1:0] s;
    logic [2:0]      l;
    agg = '0;
    for (int i = 0; i < NSET; i++) begin
      for (int j = 0; j < NSET; j++) begin
        s = (mu_e_i[i] < mu_d_i[j]) ? mu_e_i[i] : mu_d_i[j];
        l = RULE_TBL[i][j];
        if (s > agg[l]) agg[l] = s;
      end
    end
  end

  always_comb begin
    num_o = '0;
    den_o = '0;
    for (int k = 0; k < NSET; k++) begin
      num_o = num_o + $signed(NUM_W'(agg[k])) * $signed(NUM_W'((k - 3) * OUT_STEP));
      den_o = den_o + DEN_W'(agg[k]);
    end
  end
endmodule

// File: rtl/fz_divider.sv
module fz_divider #(
  parameter int N_W = 24,
  parameter int D_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quot,
  output logic           last
);
  localparam int C_W = $clog2(N_W + 1);

  logic [D_W-1:0] rem, dv;
  logic [C_W-1:0] cnt;
  logic           run;
  logic [D_W:0]   rem_sh;
  logic           fits;

  assign rem_sh = {rem, quot[N_W-1]};
  assign fits   = rem_sh >= {1'b0, dv};
  assign last   = run && (cnt == C_W'(N_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      dv   <= '0;
      quot <= '0;
      cnt  <= '0;
      run  <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      dv   <= divisor;
      quot <= dividend;
      cnt  <= '0;
      run  <= 1'b1;
    end else if (run) begin
      rem  <= fits ? D_W'(rem_sh - {1'b0, dv}) : D_W'(rem_sh);
      quot <= {quot[N_W-2:0], fits};
      cnt  <= cnt + C_W'(1);
      if (last) run <= 1'b0;
    end
  end
endmodule

// File: rtl/fz_speed_ctrl.sv
module fz_speed_ctrl #(
  parameter int IN_W     = 16,
  parameter int SH       = 8,
  parameter int OUT_W    = 12,
  parameter int OUT_STEP = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_err,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_ref
);
  import fz_pkg::*;

  localparam int MU_W    = SH + 1;
  localparam int DE_W    = IN_W + 1;
  localparam int MAG_W   = MU_W + $clog2(21 * OUT_STEP + 1);
  localparam int NUM_W   = MAG_W + 1;
  localparam int DEN_W   = MU_W + 3;
  localparam int LAT_CYC = MAG_W + 1;
  localparam logic [MAG_W-1:0] POS_LIM = MAG_W'(2 ** (OUT_W - 1) - 1);
  localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'(2 ** (OUT_W - 1));

  fz_state_e                 st;
  logic signed [IN_W-1:0]    prev_q;   // latest accepted error
  logic signed [DE_W-1:0]    d_q;
  logic                      neg_q;
  logic [NSET-1:0][MU_W-1:0] mu_e, mu_d;
  logic signed [NUM_W-1:0]   num;
  logic [DEN_W-1:0]          den;
  logic [MAG_W-1:0]          mag, quot;
  logic                      div_last;

  fz_fuzzify #(.X_W(IN_W), .SH(SH), .MU_W(MU_W)) fz_err_i (.x_i(prev_q), .mu_o(mu_e));
  fz_fuzzify #(.X_W(DE_W), .SH(SH), .MU_W(MU_W)) fz_del_i (.x_i(d_q),    .mu_o(mu_d));

  fz_rulebank #(.MU_W(MU_W), .OUT_STEP(OUT_STEP), .NUM_W(NUM_W), .DEN_W(DEN_W)) rb_i (
    .mu_e_i(mu_e), .mu_d_i(mu_d), .num_o(num), .den_o(den)
  );

  assign mag = num[NUM_W-1] ? MAG_W'(-num) : MAG_W'(num);

  fz_divider #(.N_W(MAG_W), .D_W(DEN_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(st == ST_PREP),
    .dividend(mag), .divisor(den), .quot(quot), .last(div_last)
  );

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      prev_q <= '0;
      d_q    <= '0;
      neg_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (in_valid) begin
          d_q    <= {in_err[IN_W-1], in_err} - {prev_q[IN_W-1], prev_q};
          prev_q <= in_err;
          st     <= ST_PREP;
        end
        ST_PREP: begin
          neg_q <= num[NUM_W-1];
          st    <= ST_RUN;
        end
        ST_RUN:  if (div_last) st <= ST_HOLD;
        ST_HOLD: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!neg_q) out_ref = (quot > POS_LIM) ? OUT_W'(POS_LIM) : OUT_W'(quot);
    else        out_ref = (quot > NEG_LIM) ? OUT_W'(NEG_LIM) : OUT_W'(MAG_W'(0) - quot);
  end
endmodule

// File: rtl/fz_speed_ctrl_chk.sv
module fz_speed_ctrl_chk #(
  parameter int LAT   = 25,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_ref
);
  logic        armed;
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      lat_cnt <= '0;
    end else if (in_valid && in_ready) begin
      armed   <= 1'b1;
      lat_cnt <= '0;
    end else if (out_valid) begin
      armed   <= 1'b0;
    end else if (armed) begin
      lat_cnt <= lat_cnt + 16'd1;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (armed && lat_cnt == 16'(LAT)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ref)));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind fz_speed_ctrl fz_speed_ctrl_chk #(.LAT(LAT_CYC), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_ref(out_ref)
);

// File: tb/fz_speed_ctrl_tb_top.sv
module fz_speed_ctrl_tb_top;
  localparam int LAT = 25;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic signed [15:0] in_err = '0;
  logic in_ready, out_valid;
  logic signed [11:0] out_ref;

  int n_chk = 0, n_fail = 0, m_prev = 0;

  always #10 clk = ~clk;

  fz_speed_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_ref(out_ref)
  );

  typedef int arr7_t [7];
  localparam int RT [7][7] = '{
    '{0,0,0,1,1,2,3}, '{0,0,1,1,2,3,4}, '{0,1,1,2,3,4,5}, '{1,1,2,3,4,5,5},
    '{1,2,3,4,5,5,6}, '{2,3,4,5,5,6,6}, '{3,4,5,5,6,6,6}
  };

  // R6 reference grading
  function automatic arr7_t fuzz(int x);
    arr7_t m;
    int p;
    foreach (m[k]) m[k] = 0;
    if (x <= -768)     m[0] = 256;
    else if (x >= 768) m[6] = 256;
    else begin
      p = x + 768;
      m[p / 256]     = 256 - p % 256;
      m[p / 256 + 1] = p % 256;
    end
    return m;
  endfunction

  // R7..R10 reference result
  function automatic int model(int e, int de);
    arr7_t me, md;
    int agg [7];
    int num, den, q;
    me = fuzz(e);
    md = fuzz(de);
    foreach (agg[k]) agg[k] = 0;
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++) begin
        int s;
        s = (me[i] < md[j]) ? me[i] : md[j];
        if (s > agg[RT[i][j]]) agg[RT[i][j]] = s;
      end
    num = 0; den = 0;
    for (int k = 0; k < 7; k++) begin
      num += agg[k] * (k - 3) * 1000;
      den += agg[k];
    end
    q = num / den;
    if (q > 2047)  q = 2047;
    if (q < -2048) q = -2048;
    return q;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_sample(int e, output int got, output int lat);
    @(negedge clk);
    in_valid = 1'b1;
    in_err   = 16'(e);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got = out_ref;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    m_prev = e;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_first;
    int g, l;
    do_sample(256, g, l);   // change = 256 only if stored error was zero: PS,PS -> PM
    chk(g == 2000, "R1 R5 first sample change", g, 2000);
    chk(l == LAT, "R3 latency", l, LAT);
  endtask

  task automatic t_rules;
    int g, l;
    do_sample(0, g, l);     // ZR, NS -> NS
    chk(g == -1000, "R7 cell ZR/NS", g, -1000);
    do_sample(-768, g, l);  // NB, NB -> NB, clamped
    chk(g == -2048, "R7 R10 cell NB/NB", g, -2048);
    do_sample(-768, g, l);  // NB, ZR -> NM
    chk(g == -2000, "R7 cell NB/ZR", g, -2000);
    do_sample(0, g, l);     // ZR, PB -> PM
    chk(g == 2000, "R7 cell ZR/PB", g, 2000);
  endtask

  task automatic t_interp;
    int g, l;
    do_sample(128, g, l);   // half ZR/PS on both inputs
    chk(g == 1000, "R6 R8 interpolated", g, 1000);
    do_sample(0, g, l);     // ZR full, change half NS/ZR
    chk(g == -500, "R6 R9 half membership", g, -500);
    do_sample(-100, g, l);  // -300000/356 truncated toward zero
    chk(g == -842, "R8 R9 truncation toward zero", g, -842);
  endtask

  task automatic t_clamp;
    int g, l;
    do_sample(5000, g, l);
    chk(g == 2047, "R10 positive clamp", g, 2047);
    do_sample(-5000, g, l);
    chk(g == -2048, "R10 negative clamp", g, -2048);
    do_sample(0, g, l);
    chk(g == 2000, "R6 saturated change", g, 2000);
  endtask

  task automatic t_backpressure;
    int g, l, w;
    @(negedge clk);
    in_valid = 1'b1;
    in_err   = 16'sd128;
    @(posedge clk);
    @(negedge clk);
    in_err = 16'sd5000;     // offered while busy, must be ignored
    w = 0;
    while (!out_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    for (int c = 0; c < 5; c++) begin
      chk(in_ready == 1'b0, "R2 not ready while result pending", int'(in_ready), 0);
      chk(out_valid == 1'b1 && out_ref == 12'sd1000, "R4 result held", int'(out_ref), 1000);
      @(negedge clk);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R4 release after take", int'(out_valid), 0);
    m_prev = 128;
    do_sample(128, g, l);   // change 0 only if 5000 was never stored
    chk(g == 500, "R2 R5 ignored sample not stored", g, 500);
  endtask

  task automatic t_sweep;
    int vals [12] = '{300, -450, 700, -760, 20, 1000, -1200, 767, -767, 333, -333, 600};
    foreach (vals[n]) begin
      int g, l, ex;
      ex = model(vals[n], vals[n] - m_prev);
      do_sample(vals[n], g, l);
      chk(g == ex, "R6 R7 R8 R9 sweep", g, ex);
      chk(l == LAT, "R3 sweep latency", l, LAT);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first();
    t_rules();
    t_interp();
    t_clamp();
    t_backpressure();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule